// File: doc/BRIEF.md
# Bidirectional Cascaded Sampling Pulse Generator

This block produces the internal sampling strobes of a 240-output column driver for an active-matrix panel. A horizontal start pulse arms a scan; once the pulse drops, the block waits a lead interval and then walks a strobe across the outputs, one sampling unit per half shift-clock period, with every unit held high for one full shift-clock period. Static inputs pick the walking direction, normal (one output per unit) or triple (three adjacent outputs per unit, 80 units), and the chip's place in a chain of up to four drivers. The place is turned into extra lead delay by counting clocks, so the chips in a chain need no carry wire between them.

Both-edge stepping is kept single-edge. `clk` runs at twice the shift-clock rate, so one `clk` period is one half shift-clock step. A full-cycle counter and a phase bit together form the step index (step = 2 x cycles + phase). A controller with four named states drives the sequencing. IDLE goes to ARMED when `start_i` is high. ARMED goes to DELAY when `start_i` is low. DELAY goes to SCAN when the lead step count expires, or back to ARMED when `start_i` is high. SCAN goes to IDLE after the last unit retires, or back to ARMED when `start_i` is high. A start pulse during DELAY or SCAN therefore aborts the scan and restarts the lead count.

Top module: `col_strobe_gen`

## Requirements
- R1: While `rst_n` is low, and whenever the block is idle, `strobe_o` is all zero and `busy_o` is low.
- R2: With position code 2'b11 (first chip) in normal mode, unit 0 rises after exactly 30 `clk` edges (15 shift-clock periods), counted from the first edge that samples `start_i` low after it was high.
- R3: Position code bit 1 is the first cascade bit and bit 0 the second: 2'b11 is rank 0, 2'b01 rank 1, 2'b10 rank 2, 2'b00 rank 3. The lead is 2 x (15 + rank x 120) edges in normal mode and 2 x (15 + rank x 40) edges in triple mode.
- R4: With `dir_fwd_i` high in normal mode, unit k is output k (bit k of `strobe_o`, bit 0 being the first output), so strobes walk from bit 0 up to bit 239.
- R5: With `dir_fwd_i` low, the walk is mirrored: in normal mode unit k is bit 239-k, and in triple mode unit k is group 79-k.
- R6: With `triple_i` high, unit g (forward) drives bits 3g, 3g+1 and 3g+2 together, and there are 80 units.
- R7: After lead edge L, unit k is high in the windows after edges L+k and L+k+1 (two `clk` periods, one shift-clock period), so neighbouring units overlap by one step and at most two units (2 x group size bits) are high at once.
- R8: A high `start_i` while the block is in DELAY or SCAN clears all strobes at the next edge, keeps `busy_o` high, and a fresh lead count begins when `start_i` falls again.
- R9: `busy_o` is high from the edge that samples `start_i` high until the edge after the last unit's final step. It drops at edge L+U+1, where U is the unit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-step clock, twice the shift-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Horizontal start pulse |
| dir_fwd_i | input | 1 | 1: walk from first output upward; 0: from last output downward |
| triple_i | input | 1 | 1: three adjacent outputs per unit; 0: one output per unit |
| pos_code_i | input | 2 | Cascade position code (see R3) |
| strobe_o | output | 240 | Sampling strobes, bit j for output j+1 |
| busy_o | output | 1 | High while armed, delaying or scanning |

## Verification
Every combination of direction, mode and the four position codes is run as a full scan, and the whole strobe vector is compared each step against an arithmetic model. Direction failures show as wrong bit order, mode failures as wrong group width or count, and decode or lead errors as a shifted first-strobe edge. Two abort patterns are also run, one raising the start pulse inside the lead count and one inside the scan. They separate a true restart from a scan that keeps running or one that resumes its old count.

// File: rtl/col_strobe_pkg.sv
package col_strobe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DELAY = 2'd2,
        ST_SCAN  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/csg_lead_calc.sv
module csg_lead_calc #(
    parameter int NUM_OUT  = 240,
    parameter int GRP      = 3,
    parameter int LEAD_CYC = 15,
    parameter int SW       = 10
) (
    input  logic          triple_i,
    input  logic [1:0]    pos_code_i,
    output logic [SW-1:0] lead_steps_o,
    output logic [SW-1:0] units_o
);
    localparam int UNITS_N = NUM_OUT;
    localparam int UNITS_T = NUM_OUT / GRP;

    int rank;
    int per_chip;
    int lead_int;

    always_comb begin
        unique case (pos_code_i)
            2'b11:   rank = 0;
            2'b01:   rank = 1;
            2'b10:   rank = 2;
            default: rank = 3;
        endcase
        // one chip's scan length in shift-clock periods
        per_chip     = triple_i ? (UNITS_T / 2) : (UNITS_N / 2);
        lead_int     = 2 * (LEAD_CYC + rank * per_chip);
        lead_steps_o = SW'(lead_int);
        units_o      = triple_i ? SW'(UNITS_T) : SW'(UNITS_N);
    end
endmodule

// File: rtl/csg_sequencer.sv
module csg_sequencer
    import col_strobe_pkg::*;
#(
    parameter int SW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [SW-1:0] lead_steps_i,
    input  logic [SW-1:0] units_i,
    output seq_state_t    state_o,
    output logic [SW-1:0] step_o,
    output logic          busy_o
);
    seq_state_t state_q, state_d;
    logic [SW-2:0] cyc_q;
    logic          phase_q;
    logic [SW-1:0] step;

    assign step = {cyc_q, phase_q};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ARMED;
            ST_ARMED: if (!start_i) state_d = ST_DELAY;
            ST_DELAY: begin
                if (start_i)                          state_d = ST_ARMED;
                else if (step == lead_steps_i - 1'b1) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (start_i)              state_d = ST_ARMED;
                else if (step == units_i) state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // full-cycle counter plus phase bit: both-edge stepping on one edge
    always_ff @(posedge clk) begin
        if (!rst_n || state_d != state_q ||
            !(state_q == ST_DELAY || state_q == ST_SCAN)) begin
            cyc_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
            if (phase_q) cyc_q <= cyc_q + 1'b1;
        end
    end

    always_comb begin
        state_o = state_q;
        step_o  = step;
        busy_o  = (state_q != ST_IDLE);
    end

    AST_ABORT_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DELAY || state_q == ST_SCAN) && start_i) |=> (state_q == ST_ARMED)); // R8

    AST_SCAN_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !start_i && step == units_i) |=> (state_q == ST_IDLE)); // R9

    AST_SCAN_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && $past(state_q) != ST_SCAN) |-> (step == '0)); // R2
endmodule

// File: rtl/csg_strobe_map.sv
module csg_strobe_map #(
    parameter int NUM_OUT = 240,
    parameter int GRP     = 3,
    parameter int SW      = 10
) (
    input  logic               scan_i,
    input  logic               dir_fwd_i,
    input  logic               triple_i,
    input  logic [SW-1:0]      step_i,
    output logic [NUM_OUT-1:0] strobe_o
);
    localparam int UNITS_T = NUM_OUT / GRP;

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
        localparam logic [SW-1:0] U_NF = SW'(j);
        localparam logic [SW-1:0] U_NR = SW'(NUM_OUT - 1 - j);
        localparam logic [SW-1:0] U_TF = SW'(j / GRP);
        localparam logic [SW-1:0] U_TR = SW'(UNITS_T - 1 - j / GRP);
        logic [SW-1:0] unit;
        always_comb begin
            unique case ({triple_i, dir_fwd_i})
                2'b01:   unit = U_NF;
                2'b00:   unit = U_NR;
                2'b11:   unit = U_TF;
                default: unit = U_TR;
            endcase
            strobe_o[j] = scan_i && ((step_i == unit) || (step_i == unit + 1'b1));
        end
    end
endmodule

// File: rtl/col_strobe_gen.sv
module col_strobe_gen
    import col_strobe_pkg::*;
#(
    parameter int NUM_OUT   = 240,
    parameter int GRP       = 3,
    parameter int LEAD_CYC  = 15,
    parameter int MAX_CHIPS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               dir_fwd_i,
    input  logic               triple_i,
    input  logic [1:0]         pos_code_i,
    output logic [NUM_OUT-1:0] strobe_o,
    output logic               busy_o
);
    localparam int MAX_STEPS = 2 * (LEAD_CYC + (MAX_CHIPS - 1) * (NUM_OUT / 2)) + 2;
    localparam int SW        = $clog2(MAX_STEPS + 1);

    logic [SW-1:0] lead_steps;
    logic [SW-1:0] units;
    logic [SW-1:0] step;
    seq_state_t    state;

    csg_lead_calc #(.NUM_OUT(NUM_OUT), .GRP(GRP), .LEAD_CYC(LEAD_CYC), .SW(SW)) u_lead (
        .triple_i    (triple_i),
        .pos_code_i  (pos_code_i),
        .lead_steps_o(lead_steps),
        .units_o     (units)
    );

    csg_sequencer #(.SW(SW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .lead_steps_i(lead_steps),
        .units_i     (units),
        .state_o     (state),
        .step_o      (step),
        .busy_o      (busy_o)
    );

    csg_strobe_map #(.NUM_OUT(NUM_OUT), .GRP(GRP), .SW(SW)) u_map (
        .scan_i   (state == ST_SCAN),
        .dir_fwd_i(dir_fwd_i),
        .triple_i (triple_i),
        .step_i   (step),
        .strobe_o (strobe_o)
    );

    AST_DARK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (strobe_o == '0)); // R1

    AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(strobe_o) <= 2 * GRP); // R7
endmodule

// File: tb/col_strobe_gen_test.sv
module col_strobe_gen_test;
    localparam int N = 240;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         dir_fwd_i = 1'b1;
    logic         triple_i = 1'b0;
    logic [1:0]   pos_code_i = 2'b11;
    logic [N-1:0] strobe_o;
    logic         busy_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    col_strobe_gen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_fwd_i(dir_fwd_i),
        .triple_i(triple_i), .pos_code_i(pos_code_i), .strobe_o(strobe_o), .busy_o(busy_o)
    );

    function automatic int rank_of(input logic [1:0] c);
        case (c)
            2'b11:   return 0;
            2'b01:   return 1;
            2'b10:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int lead_of(input bit t, input logic [1:0] c);
        return 2 * (15 + rank_of(c) * (t ? 40 : 120));
    endfunction

    function automatic logic [N-1:0] exp_vec(input int m, input int l2, input bit d, input bit t);
        logic [N-1:0] v = '0;
        int s = m - l2;
        int un = t ? 80 : 240;
        for (int j = 0; j < N; j++) begin
            int g = t ? j / 3 : j;
            int u = d ? g : un - 1 - g;
            if (s >= 0 && s <= un && (u == s || u == s - 1)) v[j] = 1'b1;
        end
        return v;
    endfunction

    task automatic chk_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s strobe act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic launch();
        start_i = 1'b1;
        repeat (2) @(negedge clk);
        start_i = 1'b0;
    endtask

    // compare every step from the edge that first samples start low
    task automatic follow(input bit d, input bit t, input logic [1:0] c, input int stop_m, input bit full);
        int l2 = lead_of(t, c);
        int un = t ? 80 : 240;
        int first = -1;
        int w0 = 0;
        string tag = t ? "R6" : (d ? "R4" : "R5");
        for (int m = 0; m <= stop_m; m++) begin
            @(posedge clk);
            @(negedge clk);
            chk_vec(tag, strobe_o, exp_vec(m, l2, d, t));
            chk_int("R9 busy", int'(busy_o), (m < l2 + un + 1) ? 1 : 0);
            if (first < 0 && strobe_o != '0) first = m;
            if (strobe_o[0]) w0++;
        end
        if (full) begin
            chk_int((c == 2'b11 && !t) ? "R2 first strobe edge" : "R3 first strobe edge", first, l2);
            chk_int("R7 strobe width", w0, 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_vec("R1 reset", strobe_o, '0);
        chk_int("R1 reset busy", int'(busy_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_vec("R1 idle", strobe_o, '0);
        chk_int("R1 idle busy", int'(busy_o), 0);

        for (int k = 0; k < 16; k++) begin
            bit d = k[0];
            bit t = k[1];
            logic [1:0] c = k[3:2];
            dir_fwd_i = d;
            triple_i = t;
            pos_code_i = c;
            @(negedge clk);
            launch();
            follow(d, t, c, lead_of(t, c) + (t ? 80 : 240) + 2, 1'b1);
        end

        // abort inside the scan, then inside the lead count
        for (int a = 0; a < 2; a++) begin
            int l2;
            dir_fwd_i = 1'b1;
            triple_i = 1'b0;
            pos_code_i = 2'b11;
            l2 = lead_of(1'b0, 2'b11);
            @(negedge clk);
            launch();
            follow(1'b1, 1'b0, 2'b11, (a == 0) ? l2 + 5 : 10, 1'b0);
            start_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            chk_vec("R8 abort clears", strobe_o, '0);
            chk_int("R8 abort busy", int'(busy_o), 1);
            start_i = 1'b0;
            follow(1'b1, 1'b0, 2'b11, l2 + 240 + 2, 1'b1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule